// File: doc/BRIEF.md
# Oldest-First Multi-Class Issue Selector

This block chooses which ready instructions leave the scheduler in a given cycle. Ready instructions are grouped into pools by operation class. Each pool shows its oldest few candidates to the block, ordered oldest first. Each candidate carries a sequence number and a squash flag. The block visits the classes by the age of each class's current head, smallest sequence number first. A squashed head is thrown away. A head whose class has no free functional unit causes that class to be passed over for the rest of the cycle. Any other head is granted an issue slot. The block stops once the issue width is used up or once every class has been examined. When downstream execution cannot accept instructions, the block does nothing.

Selection is combinational within the cycle. The block reports four things per class: the grants, how many entries each pool must pop, how many units it reserved, and which classes were passed over as busy. A per-class event wheel then tracks each reservation. From the class latency and its pipelined flag, the wheel produces a unit-release count and a completion count in the cycles that follow the issue.

Top module: `age_issue_sel`

## Requirements
- R1: At most ISSUE_W grants are made per cycle. Grants fill slots from slot 0 upward with no gaps, and `issued_cnt` equals the number of valid grant slots.
- R2: Heads are considered in ascending unsigned sequence number order across classes, so the grant slots carry non-decreasing sequence numbers and older heads take the lower slots.
- R3: When two class heads carry equal sequence numbers, the class with the lower index is taken first.
- R4: A squashed head is counted in its class's `pop_cnt` without using an issue slot. The next entry of that class then competes by its own sequence number.
- R5: A class other than class 0 whose head is unsquashed but which has no free unit left gets its `busy_skip` bit set. It is not examined again that cycle, its next entry is not popped, and heads in other classes, younger ones included, can still issue.
- R6: Class 0 is the no-unit class. Its heads issue regardless of `fu_avail[0]`, it never reserves a unit, and its `busy_skip` bit stays 0.
- R7: Each grant of a class c ≠ 0 reserves one unit, so `take_cnt[c]` never exceeds `fu_avail[c]`. A second grant of the same class in one cycle needs `fu_avail[c] ≥ 2`.
- R8: While `can_issue` is 0, there are no grants, every `pop_cnt` is 0 and every `busy_skip` bit is 0.
- R9: A class whose latency field is 0 or 1 is single-cycle. Its reserved units show up in `rel_cnt` in the cycle after the issue, and it produces no completion.
- R10: A class with latency L ≥ 2 and the pipelined flag set releases its units in the cycle after the issue. Its completions appear in `done_cnt` L−1 cycles after the issue cycle.
- R11: A class with latency L ≥ 2 and the pipelined flag clear holds its units. Its release and its completion both appear L−1 cycles after the issue cycle.
- R12: After reset every `rel_cnt` and `done_cnt` is 0. Class 0 issues never produce a release or a completion.
- R13: Once ISSUE_W grants have been made, the remaining heads are left alone, squashed ones included: they are not popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the event wheels |
| can_issue | input | 1 | Downstream can accept issued instructions this cycle |
| cand_vld | input | NCLS×DEPTH | Candidate present, per class and pool position (0 = oldest) |
| cand_seq | input | NCLS×DEPTH×SEQ_W | Candidate sequence number |
| cand_sqsh | input | NCLS×DEPTH | Candidate has been squashed |
| fu_avail | input | NCLS×AVAIL_W | Free units of each class this cycle |
| cls_lat | input | NCLS×LAT_W | Operation latency of each class |
| cls_pipe | input | NCLS | Class unit is pipelined |
| grant_vld | output | ISSUE_W | Issue slot holds a grant |
| grant_cls | output | ISSUE_W×CLS_W | Class of the granted instruction |
| grant_seq | output | ISSUE_W×SEQ_W | Sequence number of the granted instruction |
| pop_cnt | output | NCLS×POP_W | Entries each pool must pop (issued plus discarded) |
| take_cnt | output | NCLS×ISS_W | Units reserved per class this cycle |
| busy_skip | output | NCLS | Class passed over because no unit was free |
| issued_cnt | output | ISS_W | Grants made this cycle |
| rel_cnt | output | NCLS×EVT_W | Units released to each class this cycle |
| done_cnt | output | NCLS×EVT_W | Multi-cycle completions per class this cycle |

## Verification
The bench builds the block with four classes, two visible candidates per pool, an issue width of two, two-bit unit counts and three-bit latencies. With two candidates per pool, the width cap and the one-unit-per-class limit can both be hit while a further head is still waiting. This also lets a squashed head expose a younger entry that then loses to another class. Three-bit latencies give completion delays of several cycles, so the release of a pipelined unit and the release of a held unit land in clearly separate cycles.

// File: rtl/age_issue_pkg.sv
package age_issue_pkg;

  // Age comparison: a strictly smaller sequence number is older.
  function automatic logic seq_older(input logic [63:0] a, input logic [63:0] b);
    return a < b;
  endfunction

  // A latency field of zero behaves as a single-cycle operation.
  function automatic int eff_lat(input int unsigned lat);
    return (lat == 0) ? 1 : int'(lat);
  endfunction

  // Cycles from issue until the unit is returned.
  function automatic int rel_delay(input int unsigned lat, input logic pipe);
    int l;
    l = eff_lat(lat);
    return (l == 1 || pipe) ? 1 : l - 1;
  endfunction

  // Cycles from issue until completion; 0 means no completion event.
  function automatic int done_delay(input int unsigned lat);
    int l;
    l = eff_lat(lat);
    return (l == 1) ? 0 : l - 1;
  endfunction

endpackage

// File: rtl/age_issue_pick.sv
module age_issue_pick
  import age_issue_pkg::*;
#(
  parameter int NCLS    = 4,
  parameter int DEPTH   = 2,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int AVAIL_W = 2,
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int POP_W  = $clog2(DEPTH + 1),
  localparam int ISS_W  = $clog2(ISSUE_W + 1)
) (
  input  logic                                    can_issue,
  input  logic [NCLS-1:0][DEPTH-1:0]              cand_vld,
  input  logic [NCLS-1:0][DEPTH-1:0][SEQ_W-1:0]   cand_seq,
  input  logic [NCLS-1:0][DEPTH-1:0]              cand_sqsh,
  input  logic [NCLS-1:0][AVAIL_W-1:0]            fu_avail,
  output logic [ISSUE_W-1:0]                      grant_vld,
  output logic [ISSUE_W-1:0][CLS_W-1:0]           grant_cls,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]           grant_seq,
  output logic [NCLS-1:0][POP_W-1:0]              pop_cnt,
  output logic [NCLS-1:0][ISS_W-1:0]              take_cnt,
  output logic [NCLS-1:0]                         busy_skip,
  output logic [ISS_W-1:0]                        issued_cnt
);

  localparam int STEPS  = NCLS * (DEPTH + 1);
  localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int SLOT_W = (ISSUE_W > 1) ? $clog2(ISSUE_W) : 1;

  int               ptr_v  [NCLS];
  logic             skp_v  [NCLS];
  int               left_v [NCLS];
  int               take_v [NCLS];
  int               cnt_v;
  int               best;
  logic             found;
  logic [SEQ_W-1:0] best_seq;

  always_comb begin
    grant_vld = '0;
    grant_cls = '0;
    grant_seq = '0;
    busy_skip = '0;
    cnt_v     = 0;
    best      = 0;
    found     = 1'b0;
    best_seq  = '0;
    for (int c = 0; c < NCLS; c++) begin
      ptr_v[c]  = 0;
      skp_v[c]  = 1'b0;
      left_v[c] = int'(fu_avail[c]);
      take_v[c] = 0;
    end
    // Each step either consumes a head or retires a class, so the
    // step budget covers the worst case.
    for (int s = 0; s < STEPS; s++) begin
      found    = 1'b0;
      best     = 0;
      best_seq = '0;
      for (int c = 0; c < NCLS; c++) begin
        if (!skp_v[c] && ptr_v[c] < DEPTH) begin
          if (cand_vld[c][IDX_W'(ptr_v[c])] &&
              (!found || seq_older(64'(cand_seq[c][IDX_W'(ptr_v[c])]), 64'(best_seq)))) begin
            found    = 1'b1;
            best     = c;
            best_seq = cand_seq[c][IDX_W'(ptr_v[c])];
          end
        end
      end
      if (found && can_issue && cnt_v < ISSUE_W) begin
        if (cand_sqsh[CLS_W'(best)][IDX_W'(ptr_v[best])]) begin
          ptr_v[best] = ptr_v[best] + 1;
        end else if (best != 0 && left_v[best] == 0) begin
          skp_v[best]                = 1'b1;
          busy_skip[CLS_W'(best)]    = 1'b1;
        end else begin
          grant_vld[SLOT_W'(cnt_v)] = 1'b1;
          grant_cls[SLOT_W'(cnt_v)] = CLS_W'(best);
          grant_seq[SLOT_W'(cnt_v)] = best_seq;
          cnt_v       = cnt_v + 1;
          ptr_v[best] = ptr_v[best] + 1;
          if (best != 0) begin
            left_v[best] = left_v[best] - 1;
            take_v[best] = take_v[best] + 1;
          end
        end
      end
    end
    for (int c = 0; c < NCLS; c++) begin
      pop_cnt[c]  = POP_W'(ptr_v[c]);
      take_cnt[c] = ISS_W'(take_v[c]);
    end
    issued_cnt = ISS_W'(cnt_v);
  end

endmodule

// File: rtl/age_issue_wheel.sv
module age_issue_wheel
  import age_issue_pkg::*;
#(
  parameter int ISS_W = 2,
  parameter int LAT_W = 3,
  parameter int EVT_W = 5,
  localparam int SLOTS = 2 ** LAT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ISS_W-1:0] n_take,
  input  logic [LAT_W-1:0] lat,
  input  logic             pipe,
  output logic [EVT_W-1:0] rel_now,
  output logic [EVT_W-1:0] done_now
);

  // Slot j holds the events due j cycles from now; slot 0 is visible.
  logic [SLOTS-1:0][EVT_W-1:0] rel_q,   done_q;
  logic [SLOTS-1:0][EVT_W-1:0] rel_nxt, done_nxt;
  int                          rd, dd;

  always_comb begin
    rd       = rel_delay(32'(lat), pipe);
    dd       = done_delay(32'(lat));
    rel_nxt  = rel_q  >> EVT_W;
    done_nxt = done_q >> EVT_W;
    if (n_take != '0) begin
      rel_nxt[LAT_W'(rd - 1)] = rel_nxt[LAT_W'(rd - 1)] + EVT_W'(n_take);
      if (dd != 0)
        done_nxt[LAT_W'(dd - 1)] = done_nxt[LAT_W'(dd - 1)] + EVT_W'(n_take);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rel_q  <= '0;
      done_q <= '0;
    end else begin
      rel_q  <= rel_nxt;
      done_q <= done_nxt;
    end
  end

  assign rel_now  = rel_q[0];
  assign done_now = done_q[0];

endmodule

// File: rtl/age_issue_sel.sv
module age_issue_sel
  import age_issue_pkg::*;
#(
  parameter int NCLS    = 4,
  parameter int DEPTH   = 2,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int LAT_W   = 3,
  parameter int AVAIL_W = 2,
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int POP_W  = $clog2(DEPTH + 1),
  localparam int ISS_W  = $clog2(ISSUE_W + 1),
  localparam int EVT_W  = $clog2(ISSUE_W * (2 ** LAT_W) + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  can_issue,
  input  logic [NCLS-1:0][DEPTH-1:0]            cand_vld,
  input  logic [NCLS-1:0][DEPTH-1:0][SEQ_W-1:0] cand_seq,
  input  logic [NCLS-1:0][DEPTH-1:0]            cand_sqsh,
  input  logic [NCLS-1:0][AVAIL_W-1:0]          fu_avail,
  input  logic [NCLS-1:0][LAT_W-1:0]            cls_lat,
  input  logic [NCLS-1:0]                       cls_pipe,
  output logic [ISSUE_W-1:0]                    grant_vld,
  output logic [ISSUE_W-1:0][CLS_W-1:0]         grant_cls,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]         grant_seq,
  output logic [NCLS-1:0][POP_W-1:0]            pop_cnt,
  output logic [NCLS-1:0][ISS_W-1:0]            take_cnt,
  output logic [NCLS-1:0]                       busy_skip,
  output logic [ISS_W-1:0]                      issued_cnt,
  output logic [NCLS-1:0][EVT_W-1:0]            rel_cnt,
  output logic [NCLS-1:0][EVT_W-1:0]            done_cnt
);

  age_issue_pick #(
    .NCLS(NCLS), .DEPTH(DEPTH), .ISSUE_W(ISSUE_W),
    .SEQ_W(SEQ_W), .AVAIL_W(AVAIL_W)
  ) u_pick (
    .can_issue (can_issue),
    .cand_vld  (cand_vld),
    .cand_seq  (cand_seq),
    .cand_sqsh (cand_sqsh),
    .fu_avail  (fu_avail),
    .grant_vld (grant_vld),
    .grant_cls (grant_cls),
    .grant_seq (grant_seq),
    .pop_cnt   (pop_cnt),
    .take_cnt  (take_cnt),
    .busy_skip (busy_skip),
    .issued_cnt(issued_cnt)
  );

  // Class 0 never reserves, so its wheel stays empty.
  for (genvar c = 0; c < NCLS; c++) begin : g_wheel
    age_issue_wheel #(
      .ISS_W(ISS_W), .LAT_W(LAT_W), .EVT_W(EVT_W)
    ) u_wheel (
      .clk     (clk),
      .rst_n   (rst_n),
      .n_take  (take_cnt[c]),
      .lat     (cls_lat[c]),
      .pipe    (cls_pipe[c]),
      .rel_now (rel_cnt[c]),
      .done_now(done_cnt[c])
    );
  end

endmodule

// File: rtl/age_issue_sel_chk.sv
module age_issue_sel_chk
  import age_issue_pkg::*;
#(
  parameter int NCLS    = 4,
  parameter int DEPTH   = 2,
  parameter int ISSUE_W = 2,
  parameter int SEQ_W   = 8,
  parameter int LAT_W   = 3,
  parameter int AVAIL_W = 2,
  localparam int CLS_W  = (NCLS > 1) ? $clog2(NCLS) : 1,
  localparam int POP_W  = $clog2(DEPTH + 1),
  localparam int ISS_W  = $clog2(ISSUE_W + 1),
  localparam int EVT_W  = $clog2(ISSUE_W * (2 ** LAT_W) + 1)
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          can_issue,
  input logic [NCLS-1:0][AVAIL_W-1:0]  fu_avail,
  input logic [NCLS-1:0][LAT_W-1:0]    cls_lat,
  input logic [ISSUE_W-1:0]            grant_vld,
  input logic [ISSUE_W-1:0][SEQ_W-1:0] grant_seq,
  input logic [NCLS-1:0][POP_W-1:0]    pop_cnt,
  input logic [NCLS-1:0][ISS_W-1:0]    take_cnt,
  input logic [NCLS-1:0]               busy_skip,
  input logic [ISS_W-1:0]              issued_cnt,
  input logic [NCLS-1:0][EVT_W-1:0]    rel_cnt,
  input logic [NCLS-1:0][EVT_W-1:0]    done_cnt
);

  a_r1_count_matches: assert property (@(posedge clk) disable iff (!rst_n)
    int'(issued_cnt) == $countones(grant_vld));

  a_r8_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !can_issue |-> (grant_vld == '0 && pop_cnt == '0 && busy_skip == '0));

  a_r6_class0_free: assert property (@(posedge clk) disable iff (!rst_n)
    take_cnt[0] == '0 && !busy_skip[0]);

  a_r12_class0_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt[0] == '0 && done_cnt[0] == '0);

  for (genvar i = 1; i < ISSUE_W; i++) begin : g_slot
    a_r1_packed_slots: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld[i] |-> grant_vld[i-1]);
    a_r2_age_order: assert property (@(posedge clk) disable iff (!rst_n)
      grant_vld[i] |-> grant_seq[i] >= grant_seq[i-1]);
  end

  for (genvar c = 1; c < NCLS; c++) begin : g_cls
    a_r7_take_bound: assert property (@(posedge clk) disable iff (!rst_n)
      int'(take_cnt[c]) <= int'(fu_avail[c]));
    a_r5_busy_only_when_exhausted: assert property (@(posedge clk) disable iff (!rst_n)
      busy_skip[c] |-> int'(take_cnt[c]) == int'(fu_avail[c]));
    a_r9_single_release: assert property (@(posedge clk) disable iff (!rst_n)
      (take_cnt[c] != '0 && eff_lat(32'(cls_lat[c])) == 1)
        |=> int'(rel_cnt[c]) >= int'($past(take_cnt[c])));
  end

endmodule

bind age_issue_sel age_issue_sel_chk #(
  .NCLS(NCLS), .DEPTH(DEPTH), .ISSUE_W(ISSUE_W),
  .SEQ_W(SEQ_W), .LAT_W(LAT_W), .AVAIL_W(AVAIL_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .can_issue (can_issue),
  .fu_avail  (fu_avail),
  .cls_lat   (cls_lat),
  .grant_vld (grant_vld),
  .grant_seq (grant_seq),
  .pop_cnt   (pop_cnt),
  .take_cnt  (take_cnt),
  .busy_skip (busy_skip),
  .issued_cnt(issued_cnt),
  .rel_cnt   (rel_cnt),
  .done_cnt  (done_cnt)
);

// File: tb/age_issue_sel_test.sv
`timescale 1ns/1ps
module age_issue_sel_test;

  localparam int NCLS = 4, DEPTH = 2, ISSUE_W = 2, SEQ_W = 8, LAT_W = 3, AVAIL_W = 2;
  localparam int CLS_W = 2, POP_W = 2, ISS_W = 2, EVT_W = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic can_issue;
  logic [NCLS-1:0][DEPTH-1:0]            cand_vld;
  logic [NCLS-1:0][DEPTH-1:0][SEQ_W-1:0] cand_seq;
  logic [NCLS-1:0][DEPTH-1:0]            cand_sqsh;
  logic [NCLS-1:0][AVAIL_W-1:0]          fu_avail;
  logic [NCLS-1:0][LAT_W-1:0]            cls_lat;
  logic [NCLS-1:0]                       cls_pipe;
  logic [ISSUE_W-1:0]                    grant_vld;
  logic [ISSUE_W-1:0][CLS_W-1:0]         grant_cls;
  logic [ISSUE_W-1:0][SEQ_W-1:0]         grant_seq;
  logic [NCLS-1:0][POP_W-1:0]            pop_cnt;
  logic [NCLS-1:0][ISS_W-1:0]            take_cnt;
  logic [NCLS-1:0]                       busy_skip;
  logic [ISS_W-1:0]                      issued_cnt;
  logic [NCLS-1:0][EVT_W-1:0]            rel_cnt;
  logic [NCLS-1:0][EVT_W-1:0]            done_cnt;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  age_issue_sel uut (
    .clk(clk), .rst_n(rst_n), .can_issue(can_issue),
    .cand_vld(cand_vld), .cand_seq(cand_seq), .cand_sqsh(cand_sqsh),
    .fu_avail(fu_avail), .cls_lat(cls_lat), .cls_pipe(cls_pipe),
    .grant_vld(grant_vld), .grant_cls(grant_cls), .grant_seq(grant_seq),
    .pop_cnt(pop_cnt), .take_cnt(take_cnt), .busy_skip(busy_skip),
    .issued_cnt(issued_cnt), .rel_cnt(rel_cnt), .done_cnt(done_cnt)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_in();
    can_issue = 1'b1;
    cand_vld  = '0;
    cand_seq  = '0;
    cand_sqsh = '0;
    for (int c = 0; c < NCLS; c++) begin
      fu_avail[c] = 2'd1;
      cls_lat[c]  = 3'd1;
      cls_pipe[c] = 1'b1;
    end
  endtask

  task automatic put(input int c, input int k, input int seq, input bit sq);
    cand_vld[c][k]  = 1'b1;
    cand_seq[c][k]  = 8'(seq);
    cand_sqsh[c][k] = sq;
  endtask

  task automatic grant_is(input string req, input int slot, input int cls, input int seq);
    chk(req, $sformatf("slot%0d valid", slot), int'(grant_vld[slot]), 1);
    chk(req, $sformatf("slot%0d class", slot), int'(grant_cls[slot]), cls);
    chk(req, $sformatf("slot%0d seq", slot), int'(grant_seq[slot]), seq);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    clear_in();
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    clear_in();
    #1;
    for (int c = 0; c < NCLS; c++) begin
      chk("R12", $sformatf("reset rel%0d", c), int'(rel_cnt[c]), 0);
      chk("R12", $sformatf("reset done%0d", c), int'(done_cnt[c]), 0);
    end
    chk("R1", "idle issued", int'(issued_cnt), 0);
  endtask

  task automatic t_age();
    @(negedge clk);
    clear_in();
    put(1, 0, 30, 0); put(2, 0, 10, 0); put(3, 0, 20, 0);
    #1;
    grant_is("R2", 0, 2, 10);
    grant_is("R2", 1, 3, 20);
    chk("R1", "issued at width", int'(issued_cnt), 2);
    chk("R2", "youngest class not popped", int'(pop_cnt[1]), 0);
    chk("R7", "take class2", int'(take_cnt[2]), 1);
    @(negedge clk);
    clear_in();
    #1;
    chk("R9", "rel class2 next cycle", int'(rel_cnt[2]), 1);
    chk("R9", "rel class3 next cycle", int'(rel_cnt[3]), 1);
    chk("R9", "no rel class1", int'(rel_cnt[1]), 0);
    chk("R9", "no done class2", int'(done_cnt[2]), 0);
    idle(2);
  endtask

  task automatic t_tie();
    @(negedge clk);
    clear_in();
    put(3, 0, 7, 0); put(1, 0, 7, 0); put(2, 0, 9, 0);
    #1;
    grant_is("R3", 0, 1, 7);
    grant_is("R3", 1, 3, 7);
    idle(2);
  endtask

  task automatic t_squash();
    @(negedge clk);
    clear_in();
    put(1, 0, 5, 1); put(1, 1, 40, 0); put(2, 0, 12, 0); put(3, 0, 25, 0);
    #1;
    grant_is("R4", 0, 2, 12);
    grant_is("R4", 1, 3, 25);
    chk("R4", "squashed head popped", int'(pop_cnt[1]), 1);
    chk("R4", "issued excludes squash", int'(issued_cnt), 2);
    @(negedge clk);
    clear_in();
    put(1, 0, 5, 1); put(1, 1, 8, 0); put(2, 0, 12, 0);
    #1;
    grant_is("R4", 0, 1, 8);
    grant_is("R4", 1, 2, 12);
    chk("R4", "squash plus issue popped", int'(pop_cnt[1]), 2);
    idle(2);
  endtask

  task automatic t_busy();
    @(negedge clk);
    clear_in();
    fu_avail[1] = 2'd0;
    put(1, 0, 3, 0); put(2, 0, 6, 0); put(3, 0, 9, 0);
    #1;
    grant_is("R5", 0, 2, 6);
    grant_is("R5", 1, 3, 9);
    chk("R5", "busy flags", int'(busy_skip), 2);
    chk("R5", "busy class not popped", int'(pop_cnt[1]), 0);
    idle(2);
  endtask

  task automatic t_noclass();
    @(negedge clk);
    clear_in();
    fu_avail = '0;
    put(0, 0, 2, 0); put(0, 1, 4, 0); put(1, 0, 1, 0);
    #1;
    grant_is("R6", 0, 0, 2);
    grant_is("R6", 1, 0, 4);
    chk("R6", "busy flags", int'(busy_skip), 2);
    chk("R6", "class0 reserves nothing", int'(take_cnt[0]), 0);
    @(negedge clk);
    clear_in();
    #1;
    chk("R12", "class0 no release", int'(rel_cnt[0]), 0);
    chk("R12", "class0 no done", int'(done_cnt[0]), 0);
    idle(2);
  endtask

  task automatic t_units();
    @(negedge clk);
    clear_in();
    put(1, 0, 1, 0); put(1, 1, 2, 0); put(2, 0, 3, 0);
    #1;
    grant_is("R7", 0, 1, 1);
    grant_is("R7", 1, 2, 3);
    chk("R7", "second same-class blocked", int'(busy_skip), 2);
    chk("R7", "take class1 one unit", int'(take_cnt[1]), 1);
    @(negedge clk);
    clear_in();
    fu_avail[1] = 2'd2;
    put(1, 0, 1, 0); put(1, 1, 2, 0); put(2, 0, 3, 0);
    #1;
    grant_is("R7", 0, 1, 1);
    grant_is("R7", 1, 1, 2);
    chk("R7", "take class1 two units", int'(take_cnt[1]), 2);
    chk("R7", "class2 waits", int'(pop_cnt[2]), 0);
    @(negedge clk);
    clear_in();
    #1;
    chk("R9", "two units released", int'(rel_cnt[1]), 2);
    idle(2);
  endtask

  task automatic t_stall();
    @(negedge clk);
    clear_in();
    can_issue = 1'b0;
    fu_avail[3] = 2'd0;
    put(1, 0, 30, 0); put(2, 0, 10, 1); put(3, 0, 20, 0);
    #1;
    chk("R8", "no grants", int'(grant_vld), 0);
    chk("R8", "no pops", int'(pop_cnt), 0);
    chk("R8", "no busy", int'(busy_skip), 0);
    @(negedge clk);
    clear_in();
    #1;
    chk("R8", "no release after stall", int'(rel_cnt), 0);
    idle(2);
  endtask

  task automatic t_cap();
    @(negedge clk);
    clear_in();
    fu_avail[1] = 2'd2;
    put(1, 0, 1, 0); put(1, 1, 2, 0); put(2, 0, 3, 1);
    #1;
    grant_is("R13", 0, 1, 1);
    grant_is("R13", 1, 1, 2);
    chk("R13", "squashed head beyond cap kept", int'(pop_cnt[2]), 0);
    idle(2);
  endtask

  task automatic t_latency();
    @(negedge clk);
    clear_in();
    cls_lat[1] = 3'd4; cls_pipe[1] = 1'b1;
    cls_lat[2] = 3'd4; cls_pipe[2] = 1'b0;
    put(1, 0, 1, 0); put(2, 0, 2, 0);
    #1;
    chk("R10", "both issued", int'(issued_cnt), 2);
    @(negedge clk);
    clear_in();
    #1;
    chk("R10", "pipelined rel at +1", int'(rel_cnt[1]), 1);
    chk("R10", "no done at +1", int'(done_cnt[1]), 0);
    chk("R11", "held unit no rel at +1", int'(rel_cnt[2]), 0);
    @(negedge clk);
    #1;
    chk("R11", "no rel at +2", int'(rel_cnt[2]), 0);
    chk("R10", "no done at +2", int'(done_cnt[1]), 0);
    @(negedge clk);
    #1;
    chk("R10", "done at +3", int'(done_cnt[1]), 1);
    chk("R10", "no second rel", int'(rel_cnt[1]), 0);
    chk("R11", "rel at +3", int'(rel_cnt[2]), 1);
    chk("R11", "done at +3", int'(done_cnt[2]), 1);
    @(negedge clk);
    #1;
    chk("R11", "empty at +4", int'(rel_cnt[2]) + int'(done_cnt[2]), 0);
    @(negedge clk);
    clear_in();
    cls_lat[3] = 3'd0;
    put(3, 0, 5, 0);
    #1;
    chk("R9", "lat0 issues", int'(grant_vld[0]), 1);
    @(negedge clk);
    clear_in();
    #1;
    chk("R9", "lat0 rel at +1", int'(rel_cnt[3]), 1);
    chk("R9", "lat0 no done", int'(done_cnt[3]), 0);
    idle(2);
  endtask

  initial begin
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_age();
    t_tie();
    t_squash();
    t_busy();
    t_noclass();
    t_units();
    t_stall();
    t_cap();
    t_latency();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule